// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to an operable state. Leaving reset, it keeps the clock-enable pin low with the chip deselected for a programmable number of cycles. It then raises clock enable and gives one NOP. After that it plays a fixed script of seven commands. The script is: precharge all banks, program the extended mode register, program the base mode register with the DLL reset bit set, precharge again, two auto refreshes, and a last base mode-register load with the DLL reset bit cleared. Each command is followed by a NOP gap whose length depends on the kind of command.

Two flags tell the memory controller what it may do next. `init_done` rises when the gap after the last mode load ends. `read_ok` also requires that a set number of clock-enabled cycles have passed since the DLL reset load, so that the DLL has locked before any read. All waits are cycle-count parameters. The mode-register operating bits and the output drive strength are parameters too. A synchronous reset restarts the whole script from any point.

Top module: `ddr_powerup_seq`

## Requirements
- R1: After reset is released, `cke` stays 0 for exactly T_PWRUP cycles, and `cs_n` is 1 (DESELECT) in every cycle in which `cke` is 0.
- R2: In the first cycle with `cke` = 1 the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 4'b0111. The first real command follows in the next cycle, and `cke` never falls again until reset.
- R3: Exactly seven commands are issued, in this order: PRECHARGE (4'b0010) with addr[10]=1, LOAD MODE (4'b0000) with ba=2'b01, LOAD MODE with ba=2'b00 and addr[8]=1, PRECHARGE with addr[10]=1, AUTO REFRESH (4'b0001), AUTO REFRESH, LOAD MODE with ba=2'b00 and addr[8]=0.
- R4: The next command comes exactly T_RP cycles after each PRECHARGE, exactly T_MRD cycles after each LOAD MODE, and exactly T_RFC cycles after each AUTO REFRESH. Every cycle in between carries NOP.
- R5: The extended mode load drives addr[0]=0 (DLL enabled), addr[1]=REDUCED_DRIVE, and all other address bits 0.
- R6: Both base mode loads drive MR_OPS on the address bus, with bit 8 forced to 1 in the first (DLL reset) and to 0 in the last. They are otherwise identical.
- R7: `init_done` rises exactly T_MRD cycles after the final LOAD MODE and stays high until reset.
- R8: `read_ok` is 1 only while `init_done` is 1 and at least T_DLL cycles have passed since the DLL-reset load. It rises in the later of the cycle `init_done` rises and the cycle T_DLL after that load.
- R9: A synchronous `rst` at any point gives `cke`=0, `cs_n`=1, `init_done`=0 and `read_ok`=0 in the next cycle, and the full script then restarts with the R1 timing.
- R10: Once `init_done` is high, the block holds `cke`=1 and NOP on the command pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / mode register select |
| addr | output | ADDR_W | Address bus / mode register value |
| init_done | output | 1 | Power-up script complete |
| read_ok | output | 1 | Reads permitted (DLL lock time met) |

## Verification
The assertions take for granted that `rst` is high from time zero until after the first clock edge and changes only away from rising edges. They also assume every wait parameter is at least 2 and T_DLL is at least 1. They treat `rst` as the block's only input. The bench keeps within these limits: it drives `rst` only on falling edges, starts with reset held for several cycles, and passes parameter values that meet the minimums. Its reset pulses come in the middle of a wait and after both flags are set, so the restart is seen from both kinds of state.

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq #(
  parameter int ADDR_W = 13,
  parameter int T_PWRUP = 400,
  parameter int T_RP = 3,
  parameter int T_MRD = 2,
  parameter int T_RFC = 10,
  parameter int T_DLL = 200,
  parameter logic [ADDR_W-1:0] MR_OPS = 'h032,
  parameter bit REDUCED_DRIVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done,
  output logic              read_ok
);

  localparam int M1 = (T_PWRUP > T_RFC) ? T_PWRUP : T_RFC;
  localparam int M2 = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW = $clog2(TMAX + 1);
  localparam int DW = $clog2(T_DLL + 1);

  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_DES = 4'b1111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  typedef enum logic [4:0] {
    S_CKE_LOW, S_NOP,
    S_PRE1, S_WRP1, S_EMR, S_WMRD1, S_MR_DLL, S_WMRD2,
    S_PRE2, S_WRP2, S_REF1, S_WRFC1, S_REF2, S_WRFC2,
    S_MR, S_WMRD3, S_DONE
  } state_t;

  state_t st, nxt;
  logic [CW-1:0] cnt, cnt_load;
  logic [DW-1:0] dll_cnt;
  logic dll_run;
  logic [3:0] cmd;
  logic expired;

  assign expired = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      S_CKE_LOW: if (expired) nxt = S_NOP;
      S_NOP:     nxt = S_PRE1;
      S_PRE1:    nxt = S_WRP1;
      S_WRP1:    if (expired) nxt = S_EMR;
      S_EMR:     nxt = S_WMRD1;
      S_WMRD1:   if (expired) nxt = S_MR_DLL;
      S_MR_DLL:  nxt = S_WMRD2;
      S_WMRD2:   if (expired) nxt = S_PRE2;
      S_PRE2:    nxt = S_WRP2;
      S_WRP2:    if (expired) nxt = S_REF1;
      S_REF1:    nxt = S_WRFC1;
      S_WRFC1:   if (expired) nxt = S_REF2;
      S_REF2:    nxt = S_WRFC2;
      S_WRFC2:   if (expired) nxt = S_MR;
      S_MR:      nxt = S_WMRD3;
      S_WMRD3:   if (expired) nxt = S_DONE;
      default:   nxt = S_DONE;
    endcase
  end

  always_comb begin
    case (nxt)
      S_CKE_LOW:               cnt_load = CW'(T_PWRUP - 1);
      S_WRP1, S_WRP2:          cnt_load = CW'(T_RP - 2);
      S_WMRD1, S_WMRD2, S_WMRD3: cnt_load = CW'(T_MRD - 2);
      S_WRFC1, S_WRFC2:        cnt_load = CW'(T_RFC - 2);
      default:                 cnt_load = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_CKE_LOW;
      cnt <= CW'(T_PWRUP - 1);
    end else begin
      st <= nxt;
      if (nxt != st) cnt <= cnt_load;
      else if (!expired) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dll_run <= 1'b0;
      dll_cnt <= '0;
    end else if (st == S_MR_DLL) begin
      dll_run <= 1'b1;
      dll_cnt <= DW'(T_DLL - 1);
    end else if (dll_cnt != '0) begin
      dll_cnt <= dll_cnt - 1'b1;
    end
  end

  always_comb begin
    cke  = 1'b1;
    cmd  = C_NOP;
    ba   = 2'b00;
    addr = '0;
    case (st)
      S_CKE_LOW: begin
        cke = 1'b0;
        cmd = C_DES;
      end
      S_PRE1, S_PRE2: begin
        cmd = C_PRE;
        addr[10] = 1'b1;
      end
      S_EMR: begin
        cmd = C_LMR;
        ba = 2'b01;
        addr[1] = REDUCED_DRIVE;
      end
      S_MR_DLL: begin
        cmd = C_LMR;
        addr = MR_OPS;
        addr[8] = 1'b1;
      end
      S_MR: begin
        cmd = C_LMR;
        addr = MR_OPS;
        addr[8] = 1'b0;
      end
      S_REF1, S_REF2: cmd = C_REF;
      default: ;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign init_done = (st == S_DONE);
  assign read_ok = init_done && dll_run && (dll_cnt == '0);

endmodule

// File: rtl/ddr_powerup_seq_chk.sv
module ddr_powerup_seq_chk #(
  parameter int ADDR_W = 13,
  parameter int T_DLL = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [1:0]        ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done,
  input logic              read_ok
);
  localparam int DW = $clog2(T_DLL + 1) + 1;

  logic [3:0] cmd;
  logic is_cmd, dll_load;
  logic armed;
  logic [DW-1:0] since;

  assign cmd = {cs_n, ras_n, cas_n, we_n};
  assign is_cmd = !cs_n && (cmd != 4'b0111);
  assign dll_load = (cmd == 4'b0000) && (ba == 2'b00) && addr[8];

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      since <= '0;
    end else if (dll_load) begin
      armed <= 1'b1;
      since <= DW'(1);
    end else if (armed && cke && since < DW'(T_DLL)) begin
      since <= since + 1'b1;
    end
  end

  a_r1_low_cke_deselects: assert property (@(posedge clk) disable iff (rst)
    !cke |-> cs_n);

  a_r2_cke_never_falls: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

  a_r4_command_then_nop: assert property (@(posedge clk) disable iff (rst)
    is_cmd |=> (cmd == 4'b0111));

  a_r5_emr_value: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0000 && ba == 2'b01) |-> (addr[0] == 1'b0 && (addr >> 2) == '0));

  a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (cmd == 4'b0010) |-> addr[10]);

  a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  a_r8_read_gate: assert property (@(posedge clk) disable iff (rst)
    read_ok |-> (init_done && armed && since >= DW'(T_DLL)));

  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!cke && cs_n && !init_done && !read_ok));

  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && cmd == 4'b0111));

endmodule

bind ddr_powerup_seq ddr_powerup_seq_chk #(.ADDR_W(ADDR_W), .T_DLL(T_DLL)) u_chk (
  .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
  .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .read_ok(read_ok)
);

// File: tb/tb_ddr_powerup_seq.sv
module tb_ddr_powerup_seq;
  localparam int AW = 13;
  localparam int PW = 400;
  localparam int RP = 3;
  localparam int MRD = 2;
  localparam int RFC = 10;
  localparam int DLL = 200;
  localparam logic [AW-1:0] OPS = 13'h032;
  localparam bit RED = 1'b1;
  localparam int CAP = 700;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done, read_ok;
  logic [1:0] ba;
  logic [AW-1:0] addr;

  always #4 clk = ~clk;

  ddr_powerup_seq #(.ADDR_W(AW), .T_PWRUP(PW), .T_RP(RP), .T_MRD(MRD),
    .T_RFC(RFC), .T_DLL(DLL), .MR_OPS(OPS), .REDUCED_DRIVE(RED)) dut (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done), .read_ok(read_ok));

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int c_cyc[8];
  logic [3:0] c_cmd[8];
  logic [1:0] c_ba[8];
  logic [AW-1:0] c_addr[8];
  int n_cmd, cke_rise, rise_cmd, done_rise, rok_rise;
  int low_bad, fall_bad, gap_bad, post_bad, rok_bad;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic release_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic capture(input int ncyc);
    logic [3:0] cv;
    n_cmd = 0; cke_rise = -1; rise_cmd = -1; done_rise = -1; rok_rise = -1;
    low_bad = 0; fall_bad = 0; gap_bad = 0; post_bad = 0; rok_bad = 0;
    for (int k = 0; k < ncyc; k++) begin
      if (k > 0) begin
        @(posedge clk);
        @(negedge clk);
      end
      cv = {cs_n, ras_n, cas_n, we_n};
      if (init_done && done_rise < 0) done_rise = k;
      if (read_ok && rok_rise < 0) rok_rise = k;
      if (read_ok && !init_done) rok_bad++;
      if (!cke) begin
        if (!cs_n) low_bad++;
        if (cke_rise >= 0) fall_bad++;
      end else begin
        if (cke_rise < 0) begin
          cke_rise = k;
          rise_cmd = int'(cv);
        end
        if (!cs_n && cv != 4'b0111) begin
          if (n_cmd < 8) begin
            c_cyc[n_cmd] = k; c_cmd[n_cmd] = cv;
            c_ba[n_cmd] = ba; c_addr[n_cmd] = addr;
          end
          n_cmd++;
        end else if (cv != 4'b0111) begin
          gap_bad++;
        end
        if (done_rise >= 0 && cv != 4'b0111) post_bad++;
      end
    end
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 cke in reset", int'(cke), 0);
    check("R9 cs_n in reset", int'(cs_n), 1);
    check("R9 init_done in reset", int'(init_done), 0);
    check("R9 read_ok in reset", int'(read_ok), 0);
  endtask

  task automatic t_full_run(input string tag);
    int e[7];
    int dn, rk;
    e[0] = PW + 1;
    e[1] = e[0] + RP;
    e[2] = e[1] + MRD;
    e[3] = e[2] + MRD;
    e[4] = e[3] + RP;
    e[5] = e[4] + RFC;
    e[6] = e[5] + RFC;
    dn = e[6] + MRD;
    rk = (dn > e[2] + DLL) ? dn : e[2] + DLL;
    release_reset();
    capture(CAP);
    $display("run %s", tag);
    check("R1 cke low length", cke_rise, PW);
    check("R1 deselect while cke low", low_bad, 0);
    check("R2 nop at cke rise", rise_cmd, 7);
    check("R2 cke never falls", fall_bad, 0);
    check("R3 command count", n_cmd, 7);
    check("R3 cmd0 precharge", int'(c_cmd[0]), 4'b0010);
    check("R3 cmd0 a10", int'(c_addr[0][10]), 1);
    check("R3 cmd1 load", int'(c_cmd[1]), 4'b0000);
    check("R3 cmd1 ba", int'(c_ba[1]), 1);
    check("R3 cmd2 load", int'(c_cmd[2]), 4'b0000);
    check("R3 cmd2 ba", int'(c_ba[2]), 0);
    check("R3 cmd3 precharge", int'(c_cmd[3]), 4'b0010);
    check("R3 cmd3 a10", int'(c_addr[3][10]), 1);
    check("R3 cmd4 refresh", int'(c_cmd[4]), 4'b0001);
    check("R3 cmd5 refresh", int'(c_cmd[5]), 4'b0001);
    check("R3 cmd6 load", int'(c_cmd[6]), 4'b0000);
    check("R3 cmd6 ba", int'(c_ba[6]), 0);
    for (int i = 0; i < 7; i++) check("R4 command cycle", c_cyc[i], e[i]);
    check("R4 only nop in gaps", gap_bad, 0);
    check("R5 emr value", int'(c_addr[1]), RED ? 2 : 0);
    check("R6 dll reset load value", int'(c_addr[2]), int'(OPS | 13'h100));
    check("R6 final load value", int'(c_addr[6]), int'(OPS & ~13'h100));
    check("R7 init_done cycle", done_rise, dn);
    check("R8 read_ok cycle", rok_rise, rk);
    check("R8 read_ok without init_done", rok_bad, 0);
    check("R10 idle after done", post_bad, 0);
    check("R10 cke high after done", int'(cke), 1);
  endtask

  task automatic t_mid_reset();
    release_reset();
    capture(PW + 8);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid-wait reset cke", int'(cke), 0);
    check("R9 mid-wait reset cs_n", int'(cs_n), 1);
    check("R9 mid-wait reset init_done", int'(init_done), 0);
  endtask

  task automatic t_reset_after_done();
    check("R8 read_ok high before reset", int'(read_ok), 1);
    rst = 1'b1;
    @(negedge clk);
    check("R9 post-done reset init_done", int'(init_done), 0);
    check("R9 post-done reset read_ok", int'(read_ok), 0);
    check("R9 post-done reset cke", int'(cke), 0);
  endtask

  initial begin
    t_reset_state();
    t_full_run("first");
    t_reset_after_done();
    t_mid_reset();
    t_full_run("after mid reset");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule